// File: doc/BRIEF.md
# Byte/Word Selectable ROM Read Port

This block is a cycle-based model of a read-only memory read port. Software or a neighbouring block cannot write it: its contents come from a parameterised initial array that is computed at elaboration. At run time the port returns either a whole 16-bit word or one byte of that word. In byte mode the topmost data pin is turned around and serves as the byte-select address bit. The 16-bit data bus is tri-state. It is modelled as a data vector together with a per-bit drive-enable vector. A standby flag reports when the chip enable is released.

Three enables control the port. The chip enable is active low. The main output enable is active low. A second output enable has its active level chosen at build time: active high, active low, or ignored. Access latency is modelled in clock cycles. Data becomes valid only after the address or chip enable has been stable for `ACC_CYCLES` clock edges. It also needs the output enables to have been active for `OE_CYCLES` edges. After an address change the old data stays on the bus for `HOLD_CYCLES` cycles, and the bus then reads zero until the new access completes.

The control is a four-state machine, named below by state and transition.

States:
- `S_STANDBY`: the chip enable is released.
- `S_QUIET`: the chip is enabled but the outputs are disabled.
- `S_PENDING`: the outputs are enabled and the access is still in progress.
- `S_VALID`: the data is valid.

Transitions, evaluated at each edge in priority order:
- standby-entry: to `S_STANDBY` whenever `ce_n` is sampled high.
- quiet-entry: to `S_QUIET` when the chip is enabled but an output enable is inactive.
- access-complete: to `S_VALID` when both latency counters are satisfied.
- access-start: otherwise to `S_PENDING`. A `S_VALID`→`S_PENDING` move loads the hold counter.

Top module: `bw_rom_port`

## Requirements
- R1: Word `a` of the memory holds the low 16 bits of (a × 0x9E37) XOR `INIT_SEED`. In word mode (`word_mode`=1) with the access complete, `dout` carries the whole word, `dout[7:0]` being the low byte, and `dq_oe` is 16'hFFFF.
- R2: In byte mode (`word_mode`=0) with the access complete, `dout[7:0]` carries the low byte of the word when `lsb_in`=0 and the high byte when `lsb_in`=1. `dout[15:8]` is zero and `dq_oe` is 16'h00FF, so bit 15 is never driven in byte mode.
- R3: One edge after `ce_n` is sampled high, `standby`=1, `dq_oe`=0, `data_valid`=0 and `dout`=0, whatever the other inputs are.
- R4: With `ce_n` low, if `oe_n` is high or the second enable is inactive, then one edge later `dq_oe`=0, `data_valid`=0 and `standby`=0.
- R5: `OE2_MODE`=0 makes `oe2` active high. `OE2_MODE`=1 makes it active low. `OE2_MODE`=2 ignores `oe2` and treats it as always active.
- R6: `data_valid` rises at the first edge at which the access key has been sampled unchanged for `ACC_CYCLES` consecutive edges and both output enables have been active for `OE_CYCLES` consecutive edges. The access key is the mode, the address and, in byte mode, `lsb_in`. `data_valid` is 0 before that edge.
- R7: While an access is pending, `dq_oe` follows the mode and `data_valid`=0. After a change away from valid data, `dout` keeps the previous data for `HOLD_CYCLES` cycles and then reads zero.
- R8: During and after reset, and until the first enabled edge, `standby`=1, `data_valid`=0, `dq_oe`=0 and `dout`=0.
- R9: A change of `word_mode` restarts the access as an address change does. In word mode a change of `lsb_in` has no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ce_n | input | 1 | Chip enable, active low |
| oe_n | input | 1 | Main output enable, active low |
| oe2 | input | 1 | Second output enable, polarity set by `OE2_MODE` |
| word_mode | input | 1 | 1 = 16-bit word mode, 0 = byte mode |
| addr | input | ADDR_W | Word address |
| lsb_in | input | 1 | Byte-select address bit, used in byte mode only (shares the top data pin) |
| dout | output | 16 | Data bus value |
| dq_oe | output | 16 | Per-bit drive enable of the data bus (0 = high impedance) |
| data_valid | output | 1 | Access complete and data valid |
| standby | output | 1 | Chip enable released |

## Verification
The hardest situation to reach is the hold window. The port must already be in a valid state with the enables held, and then exactly one key input must change. Only then do the cycles that show stale data and then zero appear. The outputs must be sampled edge by edge at those cycles. Directed sequences build this steady valid state first. They then change the address, the mode, or the output enable alone and check each of the following cycles. Random stimulus with a fixed seed holds each input pattern long enough to settle. It sweeps chip enable, both output enables, mode and byte select across three instances, one for each second-enable polarity.

// File: rtl/bw_rom_pkg.sv
package bw_rom_pkg;

    typedef enum logic [1:0] {
        OE2_HIGH   = 2'd0,
        OE2_LOW    = 2'd1,
        OE2_IGNORE = 2'd2
    } oe2_pol_e;

    typedef enum logic [1:0] {
        S_STANDBY = 2'd0,
        S_QUIET   = 2'd1,
        S_PENDING = 2'd2,
        S_VALID   = 2'd3
    } port_state_e;

    // initial content of word a
    function automatic logic [15:0] rom_word(input int unsigned a, input logic [15:0] seed);
        logic [31:0] prod;
        prod = a * 32'h0000_9E37;
        return prod[15:0] ^ seed;
    endfunction

endpackage

// File: rtl/bw_rom_array.sv
module bw_rom_array #(
    parameter int          ADDR_W = 8,
    parameter logic [15:0] SEED   = 16'h5A3C
) (
    input  logic [ADDR_W-1:0] addr,
    output logic [15:0]       word
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [15:0] rom [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_init
        assign rom[g] = bw_rom_pkg::rom_word(g, SEED);
    end

    assign word = rom[addr];
endmodule

// File: rtl/bw_rom_lane_sel.sv
module bw_rom_lane_sel (
    input  logic [15:0] word,
    input  logic        word_mode,
    input  logic        byte_hi,
    output logic [15:0] lanes
);
    always_comb begin
        if (word_mode)    lanes = word;
        else if (byte_hi) lanes = {8'h00, word[15:8]};
        else              lanes = {8'h00, word[7:0]};
    end
endmodule

// File: rtl/bw_rom_sat_cnt.sv
module bw_rom_sat_cnt #(
    parameter int LIMIT = 3,
    parameter int W     = $clog2(LIMIT + 2)
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clear,
    input  logic         restart,
    output logic [W-1:0] cnt,
    output logic [W-1:0] cnt_nxt,
    output logic         done_nxt
);
    always_comb begin
        if (clear)                    cnt_nxt = '0;
        else if (restart)             cnt_nxt = W'(1);
        else if (cnt < W'(LIMIT))     cnt_nxt = cnt + 1'b1;
        else                          cnt_nxt = cnt;
    end

    assign done_nxt = (cnt_nxt >= W'(LIMIT));

    always_ff @(posedge clk) begin
        if (!rst_n) cnt <= '0;
        else        cnt <= cnt_nxt;
    end
endmodule

// File: rtl/bw_rom_port.sv
module bw_rom_port
    import bw_rom_pkg::*;
#(
    parameter int          ADDR_W      = 8,
    parameter int          ACC_CYCLES  = 3,
    parameter int          OE_CYCLES   = 2,
    parameter int          HOLD_CYCLES = 1,
    parameter logic [15:0] INIT_SEED   = 16'h5A3C,
    parameter oe2_pol_e    OE2_MODE    = OE2_HIGH
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ce_n,
    input  logic              oe_n,
    input  logic              oe2,
    input  logic              word_mode,
    input  logic [ADDR_W-1:0] addr,
    input  logic              lsb_in,
    output logic [15:0]       dout,
    output logic [15:0]       dq_oe,
    output logic              data_valid,
    output logic              standby
);
    localparam int KEY_W = ADDR_W + 2;
    localparam int AW    = $clog2(ACC_CYCLES + 2);
    localparam int OW    = $clog2(OE_CYCLES + 2);
    localparam int HW    = $clog2(HOLD_CYCLES + 2);

    port_state_e       state_q, state_d;
    logic [KEY_W-1:0]  key_q, key_d;
    logic [15:0]       data_q, lanes;
    logic [15:0]       word;
    logic [HW-1:0]     hold_q, hold_d;
    logic              oe2_ok, ce_a, en_a, key_chg;
    logic [AW-1:0]     acc_cnt, acc_nxt;
    logic [OW-1:0]     oe_cnt, oe_nxt;
    logic              acc_done, oe_done;

    // second enable polarity
    if (OE2_MODE == OE2_HIGH) begin : g_oe2_hi
        assign oe2_ok = oe2;
    end else if (OE2_MODE == OE2_LOW) begin : g_oe2_lo
        assign oe2_ok = ~oe2;
    end else begin : g_oe2_ign
        assign oe2_ok = 1'b1;
    end

    assign ce_a    = ~ce_n;
    assign en_a    = ce_a & ~oe_n & oe2_ok;
    assign key_d   = {word_mode, addr, (word_mode ? 1'b0 : lsb_in)};
    assign key_chg = (key_d != key_q);

    bw_rom_sat_cnt #(.LIMIT(ACC_CYCLES), .W(AW)) u_acc (
        .clk(clk), .rst_n(rst_n), .clear(~ce_a), .restart(key_chg),
        .cnt(acc_cnt), .cnt_nxt(acc_nxt), .done_nxt(acc_done)
    );

    bw_rom_sat_cnt #(.LIMIT(OE_CYCLES), .W(OW)) u_oe (
        .clk(clk), .rst_n(rst_n), .clear(~en_a), .restart(1'b0),
        .cnt(oe_cnt), .cnt_nxt(oe_nxt), .done_nxt(oe_done)
    );

    bw_rom_array #(.ADDR_W(ADDR_W), .SEED(INIT_SEED)) u_rom (
        .addr(addr), .word(word)
    );

    bw_rom_lane_sel u_sel (
        .word(word), .word_mode(word_mode), .byte_hi(lsb_in), .lanes(lanes)
    );

    // next state: standby-entry, quiet-entry, access-complete, access-start
    always_comb begin
        if (!ce_a)                    state_d = S_STANDBY;
        else if (!en_a)               state_d = S_QUIET;
        else if (acc_done && oe_done) state_d = S_VALID;
        else                          state_d = S_PENDING;
    end

    always_comb begin
        hold_d = '0;
        unique case (state_q)
            S_VALID:   hold_d = (state_d == S_PENDING) ? HW'(HOLD_CYCLES) : '0;
            S_PENDING: hold_d = (state_d == S_PENDING && hold_q != '0) ? hold_q - 1'b1 : '0;
            S_STANDBY, S_QUIET: hold_d = '0;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= S_STANDBY;
            key_q   <= '0;
            hold_q  <= '0;
            data_q  <= '0;
        end else begin
            state_q <= state_d;
            key_q   <= key_d;
            hold_q  <= hold_d;
            if (state_d == S_VALID) data_q <= lanes;
        end
    end

    // outputs
    always_comb begin
        dout       = '0;
        dq_oe      = '0;
        data_valid = 1'b0;
        standby    = 1'b0;
        unique case (state_q)
            S_STANDBY: standby = 1'b1;
            S_QUIET:   ;
            S_PENDING: begin
                dq_oe = key_q[KEY_W-1] ? 16'hFFFF : 16'h00FF;
                dout  = (hold_q != '0) ? data_q : '0;
            end
            S_VALID: begin
                dq_oe      = key_q[KEY_W-1] ? 16'hFFFF : 16'h00FF;
                dout       = data_q;
                data_valid = 1'b1;
            end
        endcase
    end

    AST_STANDBY_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        standby |-> (dq_oe == 16'h0 && !data_valid)); // R3
    AST_CE_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        ce_n |=> standby); // R3
    AST_OE_DISABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!ce_n && oe_n) |=> (dq_oe == 16'h0 && !standby && !data_valid)); // R4
    AST_BYTE_TOP_FREE: assert property (@(posedge clk) disable iff (!rst_n)
        (!ce_n && !word_mode) |=> !dq_oe[15]); // R2
    AST_LATENCY_MET: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(data_valid) |-> (acc_cnt >= AW'(ACC_CYCLES) && oe_cnt >= OW'(OE_CYCLES))); // R6
    AST_VALID_LANES: assert property (@(posedge clk) disable iff (!rst_n)
        data_valid |-> (dq_oe == 16'hFFFF || dq_oe == 16'h00FF)); // R1
endmodule

// File: tb/tb_bw_rom_port.sv
`timescale 1ns/1ps
module tb_bw_rom_port;
    localparam int          ADDR_W = 8;
    localparam int          ACC    = 3;
    localparam int          OEC    = 2;
    localparam int          HOLD   = 1;
    localparam logic [15:0] SEED   = 16'h5A3C;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ce_n = 1'b1, oe_n = 1'b1, oe2 = 1'b0, word_mode = 1'b1, lsb_in = 1'b0;
    logic [ADDR_W-1:0] addr = '0;

    logic [15:0] d0, e0, d1, e1, d2, e2;
    logic v0, s0, v1, s1, v2, s2;

    int checks = 0;
    int fails  = 0;

    always #2.5 clk = ~clk;

    bw_rom_port #(.ADDR_W(ADDR_W), .ACC_CYCLES(ACC), .OE_CYCLES(OEC), .HOLD_CYCLES(HOLD),
        .INIT_SEED(SEED), .OE2_MODE(bw_rom_pkg::OE2_HIGH)) dut (
        .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .oe2(oe2), .word_mode(word_mode),
        .addr(addr), .lsb_in(lsb_in), .dout(d0), .dq_oe(e0), .data_valid(v0), .standby(s0));

    bw_rom_port #(.ADDR_W(ADDR_W), .ACC_CYCLES(ACC), .OE_CYCLES(OEC), .HOLD_CYCLES(HOLD),
        .INIT_SEED(SEED), .OE2_MODE(bw_rom_pkg::OE2_LOW)) dut_lo (
        .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .oe2(oe2), .word_mode(word_mode),
        .addr(addr), .lsb_in(lsb_in), .dout(d1), .dq_oe(e1), .data_valid(v1), .standby(s1));

    bw_rom_port #(.ADDR_W(ADDR_W), .ACC_CYCLES(ACC), .OE_CYCLES(OEC), .HOLD_CYCLES(HOLD),
        .INIT_SEED(SEED), .OE2_MODE(bw_rom_pkg::OE2_IGNORE)) dut_ign (
        .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .oe2(oe2), .word_mode(word_mode),
        .addr(addr), .lsb_in(lsb_in), .dout(d2), .dq_oe(e2), .data_valid(v2), .standby(s2));

    function automatic logic [15:0] ref_word(input logic [ADDR_W-1:0] a);
        logic [31:0] m;
        m = {24'h0, a} * 32'd40503;   // 0x9E37
        return m[15:0] ^ SEED;
    endfunction

    // steady-state expectation: {dout, dq_oe, data_valid, standby}
    function automatic logic [33:0] settled(input int pol, input logic cen, input logic oen,
        input logic o2, input logic wm, input logic [ADDR_W-1:0] a, input logic lsb);
        logic [15:0] w;
        logic ok;
        w  = ref_word(a);
        ok = (pol == 0) ? o2 : (pol == 1) ? !o2 : 1'b1;
        if (cen)        return {16'h0, 16'h0, 1'b0, 1'b1};
        if (oen || !ok) return {16'h0, 16'h0, 1'b0, 1'b0};
        if (wm)         return {w, 16'hFFFF, 1'b1, 1'b0};
        return {8'h00, (lsb ? w[15:8] : w[7:0]), 16'h00FF, 1'b1, 1'b0};
    endfunction

    task automatic check(input string tag, input logic [33:0] act, input logic [33:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic step(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            #1;
        end
    endtask

    function automatic logic [33:0] p0();
        return {d0, e0, v0, s0};
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        logic [15:0] wa, wb;
        string tg;
        void'($urandom(32'd1234));
        step(3);
        check("R8 reset", p0(), {16'h0, 16'h0, 1'b0, 1'b1});
        rst_n = 1'b1;
        step(2);
        check("R8 idle after reset", p0(), {16'h0, 16'h0, 1'b0, 1'b1});

        // word read
        ce_n = 0; oe_n = 0; oe2 = 1; word_mode = 1; addr = 8'h05;
        step(6);
        check("R1 word read", p0(), settled(0, 0, 0, 1, 1, 8'h05, 0));
        addr = 8'hFF; step(6);
        check("R1 word read top", p0(), settled(0, 0, 0, 1, 1, 8'hFF, 0));

        // byte reads
        word_mode = 0; addr = 8'h7F; lsb_in = 0; step(6);
        check("R2 byte low", p0(), settled(0, 0, 0, 1, 0, 8'h7F, 0));
        lsb_in = 1; step(6);
        check("R2 byte high", p0(), settled(0, 0, 0, 1, 0, 8'h7F, 1));

        // address-change latency and hold window
        word_mode = 1; addr = 8'h10; step(6);
        wa = ref_word(8'h10); wb = ref_word(8'h21);
        addr = 8'h21;
        step(1);
        check("R7 hold old data", p0(), {wa, 16'hFFFF, 1'b0, 1'b0});
        step(1);
        check("R7 pending zero", p0(), {16'h0, 16'hFFFF, 1'b0, 1'b0});
        step(1);
        check("R6 address latency", p0(), {wb, 16'hFFFF, 1'b1, 1'b0});

        // output-enable latency
        oe_n = 1; step(4);
        check("R4 oe off", p0(), {16'h0, 16'h0, 1'b0, 1'b0});
        oe_n = 0; step(1);
        check("R6 oe pending", p0(), {16'h0, 16'hFFFF, 1'b0, 1'b0});
        step(1);
        check("R6 oe latency", p0(), {wb, 16'hFFFF, 1'b1, 1'b0});

        // word mode ignores lsb_in
        lsb_in = ~lsb_in; step(1);
        check("R9 lsb ignored word", p0(), {wb, 16'hFFFF, 1'b1, 1'b0});

        // mode change restarts access
        word_mode = 0; lsb_in = 0; step(1);
        check("R9 mode restart", {15'h0, v0}, 16'h0);
        step(2);
        check("R9 mode settled", p0(), settled(0, 0, 0, 1, 0, 8'h21, 0));

        // chip enable release
        ce_n = 1; step(1);
        check("R3 standby", p0(), {16'h0, 16'h0, 1'b0, 1'b1});

        // second enable polarity
        ce_n = 0; word_mode = 1; oe2 = 0; step(6);
        check("R5 active-high off", p0(), settled(0, 0, 0, 0, 1, 8'h21, 0));
        check("R5 active-low on", {d1, e1, v1, s1}, settled(1, 0, 0, 0, 1, 8'h21, 0));
        check("R5 ignored on", {d2, e2, v2, s2}, settled(2, 0, 0, 0, 1, 8'h21, 0));

        // random sweep
        for (int it = 0; it < 300; it++) begin
            ce_n      = ($urandom % 4) == 0;
            oe_n      = ($urandom % 4) == 0;
            oe2       = $urandom % 2;
            word_mode = $urandom % 2;
            lsb_in    = $urandom % 2;
            addr      = ADDR_W'($urandom);
            step(6);
            if (ce_n) tg = "R3 rand";
            else if (oe_n) tg = "R4 rand";
            else if (word_mode) tg = "R1 rand";
            else tg = "R2 rand";
            check(tg, p0(), settled(0, ce_n, oe_n, oe2, word_mode, addr, lsb_in));
            check("R5 rand low", {d1, e1, v1, s1}, settled(1, ce_n, oe_n, oe2, word_mode, addr, lsb_in));
            check("R5 rand ign", {d2, e2, v2, s2}, settled(2, ce_n, oe_n, oe2, word_mode, addr, lsb_in));
        end

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule